// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Power-of-Two Prescaler

This block holds an 8-bit count register that advances on one of two event sources. In timer mode the source is the instruction-cycle tick, which is the system clock divided by four. In counter mode the source is a chosen edge of an asynchronous external clock pin. Before an edge of that pin is detected, it passes through a two-flop synchronizer.

A prescaler can sit between the event source and the count register. When it is assigned, the count advances once per 2^(n+1) events, where n is a 3-bit ratio field. When it is not assigned, every event advances the count. Software can load the count at any time through a write port. A one-cycle pulse reports each wrap from 0xFF to 0x00 to the interrupt logic. A write clears the prescaler and holds off counting for two instruction cycles.

Top module: `tmr8_presc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_data` reads 0x00 and `ovf_pulse` is low until the first counted event or write.
- R2: With `cfg_ext_mode`=0 and `cfg_psc_on`=0, the count advances by one at every instruction-cycle boundary. A boundary is every fourth rising clock edge after reset release (edges 4, 8, 12 and so on), so the spacing is four clocks. Between boundaries the count does not change.
- R3: With `cfg_psc_on`=1, the count advances once per 2^(n+1) counted events, where n = `cfg_psc_sel` (0 gives /2, 7 gives /256). This applies in both modes.
- R4: With `cfg_ext_mode`=1, a counted level change on `ext_clk` is first sampled by some clock edge k. The count (with the prescaler bypassed) then shows the new value after edge k+2.
- R5: `cfg_fall_edge`=0 counts 0-to-1 transitions of `ext_clk`, and `cfg_fall_edge`=1 counts 1-to-0 transitions. The opposite transition has no effect on the count.
- R6: In timer mode, activity on `ext_clk` has no effect on the count.
- R7: When `wr_en` is high at a clock edge, `rd_data` shows `wr_data` after that edge and the prescaler restarts from zero. A write takes precedence over an increment in the same cycle.
- R8: After a write at edge w, events at the first two instruction-cycle boundaries after w are discarded. Only from the third boundary on are events counted, whether they come from the instruction tick or from `ext_clk`.
- R9: `ovf_pulse` is high for exactly the one cycle in which the count has just advanced from 0xFF to 0x00. A write never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_mode | input | 1 | 0: instruction-cycle source, 1: external pin source |
| cfg_fall_edge | input | 1 | External edge select, 0 rising, 1 falling |
| cfg_psc_on | input | 1 | 1: prescaler assigned to this counter, 0: bypassed |
| cfg_psc_sel | input | 3 | Prescaler ratio n, division by 2^(n+1) |
| ext_clk | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Count register write strobe |
| wr_data | input | 8 | Count register write value |
| rd_data | output | 8 | Current count value |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
A write is visible in the same cycle as the write edge. In timer mode the first increment after a write lands on the third instruction boundary after it, and later increments follow every 4·2^(n+1) clocks. An external edge driven just after clock edge c shows up in the count at edge c+3, and the wrap pulse coincides with the count reading 0x00. The driver computes each of these absolute cycle numbers from the write edge and the boundary grid, and it queues them together with the value. The monitor then flags any count change that arrives early, late, unannounced, or not at all.

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int PHASE_W     = 2,
  parameter int HOLD_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_mode,
  input  logic             cfg_fall_edge,
  input  logic             cfg_psc_on,
  input  logic [SEL_W-1:0] cfg_psc_sel,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             ovf_pulse
);

  localparam int PSC_W  = 1 << SEL_W;
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [PHASE_W-1:0]   phase_q;
  logic [SYNC_STAGES:0] sync_q;
  logic [PSC_W-1:0]     psc_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [HOLD_W-1:0]    hold_q;
  logic                 ovf_q;

  logic             instr_tick, ext_rise, ext_fall, src_evt, live_evt, cnt_inc;
  logic [PSC_W-1:0] psc_mask;

  assign instr_tick = &phase_q;
  assign ext_rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall   = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
  assign src_evt    = cfg_ext_mode ? (cfg_fall_edge ? ext_fall : ext_rise) : instr_tick;
  assign live_evt   = src_evt && (hold_q == '0);
  assign psc_mask   = PSC_W'((32'd2 << cfg_psc_sel) - 32'd1);
  assign cnt_inc    = live_evt && (!cfg_psc_on || ((psc_q & psc_mask) == psc_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sync_q  <= '0;
      psc_q   <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      sync_q  <= {sync_q[SYNC_STAGES-1:0], ext_clk};
      ovf_q   <= 1'b0;
      if (wr_en) begin
        cnt_q  <= wr_data;
        psc_q  <= '0;
        hold_q <= HOLD_W'(HOLD_TICKS);
      end else begin
        if (hold_q != '0 && instr_tick) hold_q <= hold_q - 1'b1;
        if (live_evt && cfg_psc_on) psc_q <= psc_q + 1'b1;
        if (cnt_inc) begin
          cnt_q <= cnt_q + 1'b1;
          ovf_q <= &cnt_q;
        end
      end
    end
  end

  assign rd_data   = cnt_q;
  assign ovf_pulse = ovf_q;

  assert_ovf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == '0);
  assert_ovf_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);
  assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)) && (psc_q == '0) && !ovf_q);
  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0 && !wr_en) |=> cnt_q == $past(cnt_q));
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  assert_timer_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_mode && !wr_en && !instr_tick) |=> $stable(cnt_q));

endmodule

// File: tb/tmr8_presc_tb.sv
module tmr8_presc_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_ext_mode = 1'b1, cfg_fall_edge = 1'b0, cfg_psc_on = 1'b0;
  logic [2:0] cfg_psc_sel = '0;
  logic       ext_clk = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;
  wire        ovf_pulse;

  tmr8_presc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_mode(cfg_ext_mode), .cfg_fall_edge(cfg_fall_edge),
    .cfg_psc_on(cfg_psc_on), .cfg_psc_sel(cfg_psc_sel), .ext_clk(ext_clk),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ovf_pulse(ovf_pulse));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [7:0] val; int at; bit ovf; string tag; } exp_t;
  exp_t exp_q[$];
  int cyc = 0, checks = 0, errors = 0;
  logic [7:0] prev_rd = '0, cur_val = '0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic void push(logic [7:0] v, int at, bit ovf, string tag);
    exp_t e;
    e.val = v; e.at = at; e.ovf = ovf; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  always @(negedge clk) if (rst_n) begin
    exp_t e;
    if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
      checks++; errors++;
      $display("FAIL %s missed change: actual %02h at cycle %0d expected %02h at cycle %0d",
               exp_q[0].tag, rd_data, cyc, exp_q[0].val, exp_q[0].at);
      void'(exp_q.pop_front());
    end
    if (rd_data !== prev_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unannounced change: actual %02h at cycle %0d expected %02h held", rd_data, cyc, prev_rd);
      end else begin
        e = exp_q.pop_front();
        if (rd_data !== e.val || cyc != e.at || ovf_pulse !== e.ovf) begin
          errors++;
          $display("FAIL %s actual %02h cyc %0d ovf %0b expected %02h cyc %0d ovf %0b",
                   e.tag, rd_data, cyc, ovf_pulse, e.val, e.at, e.ovf);
        end
      end
    end else if (ovf_pulse !== 1'b0) begin
      checks++; errors++;
      $display("FAIL R9 stray wrap pulse at cycle %0d: actual 1 expected 0", cyc);
    end
    prev_rd = rd_data;
  end

  task automatic direct(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic timer_run(bit on, int sel, logic [7:0] start, int n, bit noise, string tag);
    int w, t1, r, k;
    logic [7:0] v;
    if (start == cur_val) start = start ^ 8'h80;
    cfg_ext_mode = 1'b0; cfg_psc_on = on; cfg_psc_sel = 3'(sel);
    wr_en = 1'b1; wr_data = start;
    w = cyc + 1;
    push(start, w, 1'b0, "R7");
    t1 = (w / 4 + 1) * 4;
    r = on ? (2 << sel) : 1;
    for (int i = 1; i <= n; i++) begin
      v = start + 8'(i);
      push(v, t1 + 8 + (i * r - 1) * 4, v == 8'h00, (i == 1) ? "R8" : tag);
    end
    @(negedge clk); wr_en = 1'b0;
    k = 0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      if (noise && (k % 3 == 0)) ext_clk = ~ext_clk;
      k++;
    end
    cur_val = start + 8'(n);
  endtask

  task automatic ext_run(bit fall, bit on, int sel, logic [7:0] start, int n, int extra, string tag);
    int r;
    logic [7:0] v;
    if (start == cur_val) start = start ^ 8'h80;
    cfg_ext_mode = 1'b1; cfg_fall_edge = fall; cfg_psc_on = on; cfg_psc_sel = 3'(sel);
    ext_clk = fall; wr_en = 1'b1; wr_data = start;
    push(start, cyc + 1, 1'b0, "R7");
    @(negedge clk); wr_en = 1'b0;
    repeat (16) @(negedge clk);
    r = on ? (2 << sel) : 1;
    v = start;
    for (int e = 1; e <= n * r + extra; e++) begin
      ext_clk = ~fall;
      if (e % r == 0 && e <= n * r) begin
        v = v + 8'd1;
        push(v, cyc + 3, v == 8'h00, tag);
      end
      repeat (3) @(negedge clk);
      ext_clk = fall;
      repeat (3) @(negedge clk);
    end
    while (exp_q.size() > 0) @(negedge clk);
    cur_val = v;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    direct(rd_data === 8'h00, "R1 count in reset", rd_data, 0);
    direct(ovf_pulse === 1'b0, "R1 pulse in reset", ovf_pulse, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    direct(rd_data === 8'h00, "R1 count after release", rd_data, 0);
    direct(ovf_pulse === 1'b0, "R1 pulse after release", ovf_pulse, 0);

    timer_run(1'b0, 0, 8'h10, 6, 1'b1, "R2 R6");
    timer_run(1'b0, 0, 8'hFD, 4, 1'b0, "R9");
    for (int s = 0; s < 8; s++) timer_run(1'b1, s, 8'(8'h20 + s * 8), 2, 1'b0, "R3");

    ext_run(1'b0, 1'b0, 0, 8'h40, 4, 0, "R4");
    ext_run(1'b1, 1'b0, 0, 8'h50, 4, 0, "R5");
    ext_run(1'b1, 1'b0, 0, 8'hFE, 3, 0, "R9");
    for (int s = 0; s < 8; s++) ext_run(1'b0, 1'b1, s, 8'(8'h60 + s * 4), 2, 0, "R3");
    for (int s = 0; s < 8; s++) ext_run(1'b1, 1'b1, s, 8'(8'hA0 + s * 4), 2, 0, "R5");

    ext_run(1'b0, 1'b1, 2, 8'h01, 1, 3, "R3");
    ext_run(1'b0, 1'b1, 2, 8'h30, 2, 0, "R7");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule